// File: doc/BRIEF.md
# Serial DAC Command Front End

This block is the digital side of a 13-bit voltage-output DAC. A host writes 16-bit words over a three-wire serial link made of an active-low select, a shift clock and a data line. Every word holds a 3-bit command in its top bits and a 13-bit payload below it. The block keeps two code registers: a staging (input) register and the live DAC register that feeds the converter. Commands can write the staging register alone, write both registers together, or move staging into live. Commands also set a general-purpose user output and choose the SCLK edge on which the serial output changes. The serial output carries the bit leaving the shift register, so several devices can be daisy-chained.

A shutdown flag turns the converter off. Three things can set it: the power-down pin, the power-down lockout pin, and serial commands. The lockout pin has priority. While it is low, shutdown cannot be held, and pulling it low wakes the part. Leaving shutdown never changes the live code.

The block runs on a fast system clock. All pins are synchronised first. A three-state receiver (RX_IDLE, RX_SHIFT, RX_EXEC) frames words. RX_IDLE moves to RX_SHIFT when select goes low. RX_SHIFT moves to RX_EXEC when select rises after exactly 16 clock edges, and back to RX_IDLE when select rises after any other count. RX_EXEC always returns to RX_IDLE after one cycle, and in that cycle the command decoder acts on the word.

Top module: `dac_serial_front`

## Requirements
- R1: Words are shifted MSB first on SCLK rising edges while `cs_n` is low. Bits [15:13] are the command and bits [12:0] the payload. A word takes effect on the rising edge of `cs_n` only if exactly 16 rising SCLK edges occurred while `cs_n` was low. Frames of any other length, including 32-edge daisy-chain frames, change nothing.
- R2: Command 001 writes the payload into the staging register and leaves `dac_code` unchanged.
- R3: Command 010 writes the payload into both the staging register and `dac_code`, and clears shutdown.
- R4: Command 011 copies the staging register into `dac_code`, ignores the payload, and clears shutdown.
- R5: Command 110 drives `user_out` high and command 100 drives it low.
- R6: While `pdl` is high, `pd` high sets shutdown. Returning `pd` low does not clear it.
- R7: While `pdl` is low, shutdown is forced clear. A high-to-low edge on `pdl` wakes the block, and `dac_code` keeps its value from before the shutdown.
- R8: Command 101 sets shutdown only while `pdl` is high. Otherwise it has no effect.
- R9: Command 111 with payload bit 12 = 1 sets `dout_on_rise`. With payload bits [12:11] = 00 it clears `dout_on_rise`. With 01 it changes nothing. Command 000 changes nothing.
- R10: After reset, `dac_code` = 0, the staging register = 0, `shutdown` = 0, `user_out` = 0, `dout_on_rise` = 0 and `dout` = 0.
- R11: `dout` shows the MSB of the shift register. With `dout_on_rise` = 0 it changes on SCLK falling edges. With 1 it changes on rising edges. During a second word, `dout` therefore replays the first word MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCLK |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial shift clock |
| din | input | 1 | Serial data in |
| pd | input | 1 | Power-down request, level |
| pdl | input | 1 | Power-down lockout, low disables shutdown |
| dout | output | 1 | Serial data out for daisy-chaining |
| dac_code | output | 13 | Live DAC register |
| shutdown | output | 1 | Converter shutdown flag |
| user_out | output | 1 | General-purpose user output |
| dout_on_rise | output | 1 | 1: `dout` changes on SCLK rise; 0: on fall |

## Verification
A word's effect on `dac_code`, `user_out`, `dout_on_rise` and `shutdown` appears by the fourth clock edge after `cs_n` rises: two edges of synchroniser, one edge to enter RX_EXEC, and one edge to register. A change on `pd` or `pdl` reaches `shutdown` by the third edge. A SCLK edge reaches `dout` by the third edge. The bench waits ten clocks after raising select and eight after a pin change before sampling. It holds each SCLK phase for eight clocks and samples `dout` four clocks into the high phase and at the end of the low phase, so every sample falls well after the due cycle and before the next stimulus.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
    localparam int CMD_W = 3;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP       = 3'b000,
        CMD_LOAD_IN   = 3'b001,
        CMD_LOAD_BOTH = 3'b010,
        CMD_UPDATE    = 3'b011,
        CMD_UPO_LO    = 3'b100,
        CMD_SHDN      = 3'b101,
        CMD_UPO_HI    = 3'b110,
        CMD_MODE      = 3'b111
    } cmd_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_SHIFT,
        RX_EXEC
    } rx_state_e;
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
    parameter int               WIDTH     = 1,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= RESET_VAL;
            else if (s == 0) chain[s] <= d;
            else chain[s] <= chain[(s == 0) ? 0 : s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dacfe_frame_rx.sv
module dacfe_frame_rx
    import dacfe_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              din_s,
    input  logic              mode_rise,
    output logic              dout,
    output logic              word_valid,
    output logic [WORD_W-1:0] word
);
    localparam int CNT_MAX = WORD_W + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    rx_state_e         state_q, state_d;
    logic [WORD_W-1:0] sr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              sclk_prev, dout_fall_q;
    logic              sclk_rise, sclk_fall;

    assign sclk_rise = sclk_s & ~sclk_prev;
    assign sclk_fall = ~sclk_s & sclk_prev;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (!cs_n_s) state_d = RX_SHIFT;
            RX_SHIFT: if (cs_n_s)
                          state_d = (cnt_q == CNT_W'(WORD_W)) ? RX_EXEC : RX_IDLE;
            RX_EXEC:  state_d = RX_IDLE;
            default:  state_d = RX_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        word_valid = (state_q == RX_EXEC);
        word       = sr_q;
        dout       = mode_rise ? sr_q[WORD_W-1] : dout_fall_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q        <= '0;
            cnt_q       <= '0;
            sclk_prev   <= 1'b0;
            dout_fall_q <= 1'b0;
        end else begin
            sclk_prev <= sclk_s;
            if (state_q == RX_IDLE) cnt_q <= '0;
            if (state_q == RX_SHIFT && sclk_rise) begin
                sr_q <= {sr_q[WORD_W-2:0], din_s};
                if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
            end
            if (sclk_fall) dout_fall_q <= sr_q[WORD_W-1];
        end
    end

    a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(CNT_MAX));
    a_r1_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);
    a_r1_valid_after_select: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(cs_n_s));
endmodule

// File: rtl/dacfe_ctrl.sv
module dacfe_ctrl
    import dacfe_pkg::*;
#(
    parameter int DATA_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  cmd_e              cmd,
    input  logic [DATA_W-1:0] data,
    input  logic              pd_s,
    input  logic              pdl_s,
    output logic [DATA_W-1:0] dac_code,
    output logic              shutdown,
    output logic              user_out,
    output logic              mode_rise
);
    logic [DATA_W-1:0] in_q, in_d, dac_q, dac_d;
    logic              sd_q, sd_d, upo_q, upo_d, mode_q, mode_d;
    logic              wake, sleep_cmd;

    always_comb begin
        in_d      = in_q;
        dac_d     = dac_q;
        upo_d     = upo_q;
        mode_d    = mode_q;
        wake      = 1'b0;
        sleep_cmd = 1'b0;
        if (word_valid) begin
            unique case (cmd)
                CMD_NOP:       ;
                CMD_LOAD_IN:   in_d = data;
                CMD_LOAD_BOTH: begin in_d = data; dac_d = data; wake = 1'b1; end
                CMD_UPDATE:    begin dac_d = in_q; wake = 1'b1; end
                CMD_UPO_LO:    upo_d = 1'b0;
                CMD_SHDN:      sleep_cmd = 1'b1;
                CMD_UPO_HI:    upo_d = 1'b1;
                CMD_MODE: begin
                    if (data[DATA_W-1])       mode_d = 1'b1;
                    else if (!data[DATA_W-2]) mode_d = 1'b0;
                end
                default: ;
            endcase
        end
        // lockout low dominates, then entry, then exit
        if (!pdl_s)                 sd_d = 1'b0;
        else if (pd_s || sleep_cmd) sd_d = 1'b1;
        else if (wake)              sd_d = 1'b0;
        else                        sd_d = sd_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q   <= '0;
            dac_q  <= '0;
            sd_q   <= 1'b0;
            upo_q  <= 1'b0;
            mode_q <= 1'b0;
        end else begin
            in_q   <= in_d;
            dac_q  <= dac_d;
            sd_q   <= sd_d;
            upo_q  <= upo_d;
            mode_q <= mode_d;
        end
    end

    assign dac_code  = dac_q;
    assign shutdown  = sd_q;
    assign user_out  = upo_q;
    assign mode_rise = mode_q;

    a_r2_dac_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_valid && (cmd == CMD_LOAD_BOTH || cmd == CMD_UPDATE)) |=> $stable(dac_q));
    a_r7_lockout: assert property (@(posedge clk) disable iff (!rst_n)
        !pdl_s |=> !sd_q);
    a_r6_pin_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_s && pdl_s) |=> sd_q);
    a_r5_upo_high: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && cmd == CMD_UPO_HI) |=> upo_q);
endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front
    import dacfe_pkg::*;
#(
    parameter int DATA_W      = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    input  logic              pd,
    input  logic              pdl,
    output logic              dout,
    output logic [DATA_W-1:0] dac_code,
    output logic              shutdown,
    output logic              user_out,
    output logic              dout_on_rise
);
    localparam int WORD_W = CMD_W + DATA_W;

    logic [4:0]        pins_s;
    logic              word_valid, mode_rise;
    logic [WORD_W-1:0] word;

    dacfe_sync #(
        .WIDTH(5), .STAGES(SYNC_STAGES), .RESET_VAL(5'b10000)
    ) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({cs_n, sclk, din, pd, pdl}),
        .q(pins_s)
    );

    dacfe_frame_rx #(.WORD_W(WORD_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .cs_n_s(pins_s[4]), .sclk_s(pins_s[3]), .din_s(pins_s[2]),
        .mode_rise(mode_rise),
        .dout(dout), .word_valid(word_valid), .word(word)
    );

    dacfe_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .word_valid(word_valid),
        .cmd(cmd_e'(word[WORD_W-1 -: CMD_W])),
        .data(word[DATA_W-1:0]),
        .pd_s(pins_s[1]), .pdl_s(pins_s[0]),
        .dac_code(dac_code), .shutdown(shutdown),
        .user_out(user_out), .mode_rise(mode_rise)
    );

    assign dout_on_rise = mode_rise;
endmodule

// File: tb/dac_serial_front_test.sv
module dac_serial_front_test;
    localparam int H = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, cs_n, sclk, din, pd, pdl;
    logic dout, shutdown, user_out, dout_on_rise;
    logic [12:0] dac_code;

    dac_serial_front uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .pd(pd), .pdl(pdl), .dout(dout), .dac_code(dac_code),
        .shutdown(shutdown), .user_out(user_out), .dout_on_rise(dout_on_rise)
    );

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic [12:0] m_in, m_dac;
    logic m_upo, m_mode, m_sd;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_frame(logic [31:0] bits, int n);
        cs_n = 1'b0; clks(4);
        for (int i = 0; i < n; i++) begin
            din = bits[n-1-i]; clks(H);
            sclk = 1'b1; clks(H);
            sclk = 1'b0;
        end
        clks(4); cs_n = 1'b1; clks(10);
    endtask

    function automatic void model(logic [2:0] c, logic [12:0] d);
        case (c)
            3'd1: m_in = d;
            3'd2: begin m_in = d; m_dac = d; if (!pd) m_sd = 1'b0; end
            3'd3: begin m_dac = m_in; if (!pd) m_sd = 1'b0; end
            3'd4: m_upo = 1'b0;
            3'd5: if (pdl) m_sd = 1'b1;
            3'd6: m_upo = 1'b1;
            3'd7: if (d[12]) m_mode = 1'b1; else if (!d[11]) m_mode = 1'b0;
            default: ;
        endcase
    endfunction

    task automatic send(logic [2:0] c, logic [12:0] d);
        shift_frame({16'h0, c, d}, 16);
        model(c, d);
    endtask

    task automatic check_all(string req);
        chk({req, " dac_code"}, 32'(dac_code), 32'(m_dac));
        chk({req, " user_out"}, 32'(user_out), 32'(m_upo));
        chk({req, " dout_on_rise"}, 32'(dout_on_rise), 32'(m_mode));
        chk({req, " shutdown"}, 32'(shutdown), 32'(m_sd));
    endtask

    // R11: 32-edge frame, dout replays the first word during the second
    task automatic daisy(logic [15:0] a, logic [15:0] b, logic mode1);
        logic [31:0] s;
        s = {a, b};
        cs_n = 1'b0; clks(4);
        for (int i = 0; i < 32; i++) begin
            din = s[31-i]; clks(H - 1);
            if (i >= 16) chk("R11 dout before rise", 32'(dout), 32'(s[47-i]));
            clks(1);
            sclk = 1'b1; clks(H / 2);
            if (i >= 16)
                chk("R11 dout mid high", 32'(dout), mode1 ? 32'(s[46-i]) : 32'(s[47-i]));
            clks(H - H / 2);
            sclk = 1'b0;
        end
        clks(4); cs_n = 1'b1; clks(10);
        check_all("R1 32-edge frame ignored");
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd2718));
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; din = 1'b0; pd = 1'b0; pdl = 1'b1;
        m_in = '0; m_dac = '0; m_upo = 1'b0; m_mode = 1'b0; m_sd = 1'b0;
        clks(5); rst_n = 1'b1; clks(6);

        check_all("R10 reset");
        chk("R10 dout reset", 32'(dout), 32'd0);

        send(3'd1, 13'h1ABC); check_all("R2 load staging only");
        send(3'd3, 13'h0005); check_all("R4 update ignores payload");
        send(3'd2, 13'h0123); check_all("R3 load both");

        shift_frame({16'h0, 3'd2, 13'h1FFF}, 15); check_all("R1 15-edge frame ignored");
        shift_frame({15'h0, 3'd2, 13'h1FFF, 1'b0}, 17); check_all("R1 17-edge frame ignored");

        send(3'd5, 13'h0); check_all("R8 command shutdown");
        send(3'd2, 13'h0456); check_all("R3 load both exits shutdown");
        send(3'd1, 13'h0777);
        send(3'd5, 13'h0);
        send(3'd3, 13'h1111); check_all("R4 update exits shutdown");

        pd = 1'b1; clks(8); m_sd = 1'b1; check_all("R6 pd enters shutdown");
        pd = 1'b0; clks(8); check_all("R6 pd low keeps shutdown");
        pdl = 1'b0; clks(8); m_sd = 1'b0; check_all("R7 pdl fall wakes, code kept");
        pd = 1'b1; clks(8); check_all("R7 lockout blocks pd");
        send(3'd5, 13'h0); check_all("R8 lockout blocks command");
        pd = 1'b0; pdl = 1'b1; clks(8); check_all("R7 lockout release");

        send(3'd6, 13'h0); check_all("R5 user out high");
        send(3'd4, 13'h1FFF); check_all("R5 user out low");
        send(3'd7, 13'h1000); check_all("R9 mode rise");
        send(3'd7, 13'h0800); check_all("R9 code 01 no effect");
        send(3'd0, 13'h1FFF); check_all("R9 nop");
        daisy(16'hA5C3, 16'h3C5A, 1'b1);
        send(3'd7, 13'h0000); check_all("R9 mode fall");
        daisy(16'h6E91, 16'hF00D, 1'b0);

        for (int k = 0; k < 40; k++) begin
            logic [2:0]  c;
            logic [12:0] d;
            int          len;
            c = 3'($urandom % 8);
            d = 13'($urandom);
            if ($urandom % 5 == 0) begin
                len = ($urandom % 2 == 0) ? 1 + int'($urandom % 15) : 17 + int'($urandom % 4);
                shift_frame({$urandom}, len);
                check_all("R1 random short or long frame");
            end else begin
                send(c, d);
                check_all("R2 random word");
            end
        end

        finish_run();
    end
endmodule